// File: doc/BRIEF.md
# Escalation Timeout and Phase Sequencer

This block runs the escalation response for one alert class. It stays in an idle state until something calls for escalation. An interrupt that is pending while the class is enabled can start an optional response timer. If software does not service the interrupt before the timer expires, escalation begins. A trigger from the class accumulator skips the timer and starts escalation at once.

Escalation steps through four phases, each with its own programmed length. After the last phase the block rests in a terminal state. Four escalation outputs each have their own enable and a two-bit field that selects the phase in which the output is asserted.

An accepted clear command stops escalation at any point. The counter output shows how many cycles have passed in the current timer or phase.

The states and their transitions, with the 3-bit code driven on `state_o`:
- Idle (000) goes to Wait (001) when a wait is requested, or to Phase0 (100) on a trigger.
- Wait (001) goes to Idle when the interrupt is withdrawn. It goes to Phase0 when the timer expires or a trigger arrives.
- Phase0 (100) goes to Phase1 (101), then Phase2 (110), then Phase3 (111), each on expiry of its own length. Phase3 goes to Terminal (011) when its length expires.
- Any phase, and Terminal, goes to Idle on clear.

Top module: `esc_phase_seq`

## Requirements
- R1: After reset `state_o` is 000 (Idle), `cnt_o` is 0 and `esc_o` is 0. State codes are Idle=000, Wait=001, Terminal=011, Phase0=100, Phase1=101, Phase2=110 and Phase3=111. Code 010 never appears.
- R2: From Idle, when `class_en_i`=1, `irq_pend_i`=1, `tmo_cyc_i`≠0 and `trig_i`=0, the state becomes Wait (001) after the next clock edge, with `cnt_o`=0.
- R3: The block stays in Idle when `tmo_cyc_i`=0 or `class_en_i`=0, even with `irq_pend_i`=1.
- R4: The block stays in Wait for exactly `tmo_cyc_i` cycles while `irq_pend_i` stays 1. After that it enters Phase0 (100).
- R5: In Wait, `irq_pend_i`=0 with no accepted trigger returns the block to Idle on the next edge.
- R6: `trig_i`=1 with `class_en_i`=1 moves the block from Idle or Wait to Phase0 on the next edge. With `class_en_i`=0 the trigger is ignored.
- R7: Phase k lasts `phase_cyc_i[k*CNT_W +: CNT_W]` cycles, and a programmed length of 0 counts as 1 cycle. The phases run in the order Phase0, Phase1, Phase2, Phase3, and Terminal follows Phase3.
- R8: `esc_o[i]` is 1 exactly when `sig_en_i[i]`=1, the state is a phase, and the phase index (state bits 1:0) equals `sig_map_i[2*i +: 2]`.
- R9: `clr_i`=1 in any phase or in Terminal returns the block to Idle on the next edge. In Idle or Wait, `clr_i` has no effect.
- R10: Terminal holds until a clear arrives, and every `esc_o` bit is 0 while in Terminal.
- R11: `cnt_o` counts the cycles already spent in the current Wait or phase, starting from 0 on entry. It is 0 in Idle and in Terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger from the class accumulator |
| irq_pend_i | input | 1 | Class interrupt pending level |
| class_en_i | input | 1 | Class escalation enable |
| tmo_cyc_i | input | CNT_W | Interrupt response timeout; 0 disables it |
| phase_cyc_i | input | 4*CNT_W | Phase lengths, phase k at bits k*CNT_W |
| sig_en_i | input | N_SIG | Per-output enable |
| sig_map_i | input | 2*N_SIG | Per-output phase select, output i at bits 2*i |
| clr_i | input | 1 | Accepted clear command |
| state_o | output | 3 | Current state code |
| cnt_o | output | CNT_W | Current wait or phase cycle count |
| esc_o | output | N_SIG | Escalation outputs |

## Verification
A wrong state register is visible on `state_o` in the same cycle it occurs. If it puts the block in the wrong phase, `esc_o` shows the wrong set of asserted signals in that cycle as well. A counter that is off by one does not change the state right away. It shows on `cnt_o` at once and moves a phase boundary by one cycle, so the bench compares every output on every cycle against a cycle-level model and catches such a fault within a single phase.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

    localparam int NUM_PHASES = 4;
    localparam int PH_IDX_W   = $clog2(NUM_PHASES);

    typedef enum logic [2:0] {
        ST_IDLE = 3'b000,
        ST_WAIT = 3'b001,
        ST_TERM = 3'b011,
        ST_PH0  = 3'b100,
        ST_PH1  = 3'b101,
        ST_PH2  = 3'b110,
        ST_PH3  = 3'b111
    } esc_state_e;

    function automatic logic is_phase(input esc_state_e st);
        return st[2];
    endfunction

endpackage

// File: rtl/esc_seq_limit.sv
module esc_seq_limit
    import esc_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  esc_state_e                  state_i,
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic [CNT_W-1:0]            tmo_cyc_i,
    input  logic [NUM_PHASES*CNT_W-1:0] phase_cyc_i,
    output logic                        done_o
);

    logic [CNT_W-1:0] ph_len [NUM_PHASES];
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   cnt_next;

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_len
        assign ph_len[k] = phase_cyc_i[k*CNT_W +: CNT_W];
    end

    always_comb begin
        if (is_phase(state_i)) limit = ph_len[state_i[PH_IDX_W-1:0]];
        else                   limit = tmo_cyc_i;
    end

    // A length of zero is treated as one cycle.
    assign cnt_next = {1'b0, cnt_i} + {{CNT_W{1'b0}}, 1'b1};
    assign done_o   = (cnt_next >= {1'b0, limit});

endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
    import esc_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic             irq_pend_i,
    input  logic             class_en_i,
    input  logic             tmo_nz_i,
    input  logic             done_i,
    input  logic             clr_i,
    output esc_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);

    esc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             trig_ok;
    logic             counting;

    assign trig_ok = class_en_i && trig_i;

    always_comb begin
        state_d  = state_q;
        counting = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_ok)                                  state_d = ST_PH0;
                else if (class_en_i && irq_pend_i && tmo_nz_i) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (trig_ok)          state_d = ST_PH0;
                else if (!irq_pend_i) state_d = ST_IDLE;
                else if (done_i)      state_d = ST_PH0;
                else                  counting = 1'b1;
            end
            ST_PH0: begin
                if (clr_i)       state_d = ST_IDLE;
                else if (done_i) state_d = ST_PH1;
                else             counting = 1'b1;
            end
            ST_PH1: begin
                if (clr_i)       state_d = ST_IDLE;
                else if (done_i) state_d = ST_PH2;
                else             counting = 1'b1;
            end
            ST_PH2: begin
                if (clr_i)       state_d = ST_IDLE;
                else if (done_i) state_d = ST_PH3;
                else             counting = 1'b1;
            end
            ST_PH3: begin
                if (clr_i)       state_d = ST_IDLE;
                else if (done_i) state_d = ST_TERM;
                else             counting = 1'b1;
            end
            ST_TERM: begin
                if (clr_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_d = counting ? cnt_q + {{(CNT_W-1){1'b0}}, 1'b1} : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/esc_seq_outmap.sv
module esc_seq_outmap
    import esc_seq_pkg::*;
#(
    parameter int N_SIG = 4
) (
    input  esc_state_e                  state_i,
    input  logic [N_SIG-1:0]            sig_en_i,
    input  logic [N_SIG*PH_IDX_W-1:0]   sig_map_i,
    output logic [N_SIG-1:0]            esc_o
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        always_comb begin
            esc_o[g] = sig_en_i[g] && is_phase(state_i) &&
                       (state_i[PH_IDX_W-1:0] == sig_map_i[g*PH_IDX_W +: PH_IDX_W]);
        end
    end

endmodule

// File: rtl/esc_phase_seq.sv
module esc_phase_seq
    import esc_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SIG = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        trig_i,
    input  logic                        irq_pend_i,
    input  logic                        class_en_i,
    input  logic [CNT_W-1:0]            tmo_cyc_i,
    input  logic [NUM_PHASES*CNT_W-1:0] phase_cyc_i,
    input  logic [N_SIG-1:0]            sig_en_i,
    input  logic [N_SIG*PH_IDX_W-1:0]   sig_map_i,
    input  logic                        clr_i,
    output logic [2:0]                  state_o,
    output logic [CNT_W-1:0]            cnt_o,
    output logic [N_SIG-1:0]            esc_o
);

    esc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             lim_done;

    esc_seq_limit #(.CNT_W(CNT_W)) u_limit (
        .state_i     (state),
        .cnt_i       (cnt),
        .tmo_cyc_i   (tmo_cyc_i),
        .phase_cyc_i (phase_cyc_i),
        .done_o      (lim_done)
    );

    esc_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trig_i     (trig_i),
        .irq_pend_i (irq_pend_i),
        .class_en_i (class_en_i),
        .tmo_nz_i   (tmo_cyc_i != '0),
        .done_i     (lim_done),
        .clr_i      (clr_i),
        .state_o    (state),
        .cnt_o      (cnt)
    );

    esc_seq_outmap #(.N_SIG(N_SIG)) u_outmap (
        .state_i   (state),
        .sig_en_i  (sig_en_i),
        .sig_map_i (sig_map_i),
        .esc_o     (esc_o)
    );

    assign state_o = state;
    assign cnt_o   = cnt;

endmodule

// File: rtl/esc_phase_seq_chk.sv
module esc_phase_seq_chk #(
    parameter int CNT_W = 16,
    parameter int N_SIG = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             trig_i,
    input logic             irq_pend_i,
    input logic             class_en_i,
    input logic             clr_i,
    input logic [2:0]       state_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [N_SIG-1:0] esc_o
);

    // R1
    legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 3'b010);

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'b000 && !class_en_i) |=> state_o == 3'b000);

    // R5
    wait_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'b001 && !irq_pend_i && !(trig_i && class_en_i)) |=> state_o == 3'b000);

    // R6
    trig_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_o == 3'b000 || state_o == 3'b001) && trig_i && class_en_i) |=> state_o == 3'b100);

    // R7
    phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o[2] && state_o != 3'b111 && !clr_i) |=>
            (state_o == $past(state_o) || state_o == $past(state_o) + 3'd1));

    // R7
    last_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'b111 && !clr_i) |=> (state_o == 3'b111 || state_o == 3'b011));

    // R8
    esc_phase_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !state_o[2] |-> esc_o == '0);

    // R9
    clr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_o[2] || state_o == 3'b011) && clr_i) |=> state_o == 3'b000);

    // R10
    term_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'b011 && !clr_i) |=> state_o == 3'b011);

    // R11
    cnt_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'b000 || state_o == 3'b011) |-> cnt_o == '0);

endmodule

bind esc_phase_seq esc_phase_seq_chk #(.CNT_W(CNT_W), .N_SIG(N_SIG)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .irq_pend_i (irq_pend_i),
    .class_en_i (class_en_i),
    .clr_i      (clr_i),
    .state_o    (state_o),
    .cnt_o      (cnt_o),
    .esc_o      (esc_o)
);

// File: tb/esc_phase_seq_bench.sv
module esc_phase_seq_bench;

    localparam int CNT_W = 16;
    localparam int N_SIG = 4;

    logic                 clk = 1'b0;
    logic                 rst_ni = 1'b0;
    logic                 trig_i = 1'b0;
    logic                 irq_pend_i = 1'b0;
    logic                 class_en_i = 1'b0;
    logic [CNT_W-1:0]     tmo_cyc_i = '0;
    logic [4*CNT_W-1:0]   phase_cyc_i = '0;
    logic [N_SIG-1:0]     sig_en_i = '1;
    logic [2*N_SIG-1:0]   sig_map_i = 8'b11_10_01_00;
    logic                 clr_i = 1'b0;
    logic [2:0]           state_o;
    logic [CNT_W-1:0]     cnt_o;
    logic [N_SIG-1:0]     esc_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [2:0] m_st  = 3'b000;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    esc_phase_seq #(.CNT_W(CNT_W), .N_SIG(N_SIG)) u_esc_phase_seq (
        .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i), .irq_pend_i(irq_pend_i),
        .class_en_i(class_en_i), .tmo_cyc_i(tmo_cyc_i), .phase_cyc_i(phase_cyc_i),
        .sig_en_i(sig_en_i), .sig_map_i(sig_map_i), .clr_i(clr_i),
        .state_o(state_o), .cnt_o(cnt_o), .esc_o(esc_o)
    );

    function automatic int len_of(input logic [2:0] st);
        int l;
        if (st[2]) l = int'(phase_cyc_i[int'(st[1:0])*CNT_W +: CNT_W]);
        else       l = int'(tmo_cyc_i);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic logic [N_SIG-1:0] exp_esc(input logic [2:0] st);
        logic [N_SIG-1:0] e = '0;
        for (int i = 0; i < N_SIG; i++)
            e[i] = sig_en_i[i] && st[2] && (sig_map_i[2*i +: 2] == st[1:0]);
        return e;
    endfunction

    // Model of the requirements, advanced once per clock edge.
    task automatic model_step();
        logic [2:0] nx = m_st;
        bit         stay = 1'b0;
        bool_go: begin end
        case (m_st)
            3'b000: if (class_en_i && trig_i) nx = 3'b100;
                    else if (class_en_i && irq_pend_i && tmo_cyc_i != 0) nx = 3'b001;
            3'b001: if (class_en_i && trig_i) nx = 3'b100;
                    else if (!irq_pend_i) nx = 3'b000;
                    else if (m_cnt + 1 >= len_of(m_st)) nx = 3'b100;
                    else stay = 1'b1;
            3'b011: if (clr_i) nx = 3'b000;
            default: if (clr_i) nx = 3'b000;
                     else if (m_cnt + 1 >= len_of(m_st)) nx = (m_st == 3'b111) ? 3'b011 : m_st + 3'd1;
                     else stay = 1'b1;
        endcase
        m_cnt = stay ? m_cnt + 1 : 0;
        m_st  = nx;
    endtask

    function automatic string tag_of(input logic [2:0] st);
        case (st)
            3'b000:  return "R2";
            3'b001:  return "R4";
            3'b011:  return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [N_SIG-1:0] ee = exp_esc(m_st);
        n_vec++;
        if (state_o !== m_st) begin
            n_bad++;
            $display("FAIL %s state act=%b exp=%b", tag, state_o, m_st);
        end else if (cnt_o !== CNT_W'(m_cnt)) begin
            n_bad++;
            $display("FAIL R11 (%s) cnt act=%0d exp=%0d", tag, cnt_o, m_cnt);
        end else if (esc_o !== ee) begin
            n_bad++;
            $display("FAIL R8 (%s) esc act=%b exp=%b", tag, esc_o, ee);
        end
    endtask

    task automatic step(input string tag);
        string t = (tag == "") ? tag_of(m_st) : tag;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(t);
    endtask

    task automatic lit(input string tag, input logic [2:0] exp_st);
        n_vec++;
        if (state_o !== exp_st) begin
            n_bad++;
            $display("FAIL %s literal state act=%b exp=%b", tag, state_o, exp_st);
        end
    endtask

    task automatic set_phases(input int a, input int b, input int c, input int d);
        phase_cyc_i = {CNT_W'(d), CNT_W'(c), CNT_W'(b), CNT_W'(a)};
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset values
        n_vec++;
        if (state_o !== 3'b000 || cnt_o !== '0 || esc_o !== '0) begin
            n_bad++;
            $display("FAIL R1 reset act=%b/%0d/%b exp=000/0/0000", state_o, cnt_o, esc_o);
        end
        rst_ni = 1'b1;
        set_phases(2, 3, 1, 2);

        // R3: zero timeout keeps Idle
        class_en_i = 1'b1; irq_pend_i = 1'b1; tmo_cyc_i = 0;
        step("R3"); step("R3"); lit("R3", 3'b000);
        // R3: disabled class keeps Idle
        class_en_i = 1'b0; tmo_cyc_i = 3;
        step("R3"); lit("R3", 3'b000);
        // R6: trigger ignored when disabled
        trig_i = 1'b1; step("R6"); trig_i = 1'b0; lit("R6", 3'b000);
        // R9: clear in Idle has no effect
        clr_i = 1'b1; class_en_i = 1'b1; irq_pend_i = 1'b0; step("R9"); clr_i = 1'b0;
        lit("R9", 3'b000);
        // R2, R4: wait of 3 cycles then Phase0
        irq_pend_i = 1'b1;
        step("R2"); lit("R2", 3'b001);
        step("R4"); step("R4"); lit("R4", 3'b001);
        step("R4"); lit("R4", 3'b100);
        // R7: walk the phases, R8 outputs checked per cycle
        for (int i = 0; i < 8; i++) step("R7");
        lit("R10", 3'b011);
        // R10: hold in Terminal
        irq_pend_i = 1'b0;
        for (int i = 0; i < 4; i++) step("R10");
        lit("R10", 3'b011);
        // R9: clear from Terminal
        clr_i = 1'b1; step("R9"); clr_i = 1'b0; lit("R9", 3'b000);
        // R5: interrupt withdrawn during wait
        tmo_cyc_i = 10; irq_pend_i = 1'b1;
        step("R2"); step("R5"); irq_pend_i = 1'b0; step("R5"); lit("R5", 3'b000);
        // R6: trigger during wait
        irq_pend_i = 1'b1; step("R2"); trig_i = 1'b1; step("R6"); trig_i = 1'b0;
        lit("R6", 3'b100);
        // R8: remapped outputs, one disabled
        sig_map_i = 8'b00_00_11_01; sig_en_i = 4'b1011;
        irq_pend_i = 1'b0;
        for (int i = 0; i < 3; i++) step("R8");
        // R9: clear mid phase
        clr_i = 1'b1; step("R9"); clr_i = 1'b0; lit("R9", 3'b000);
        // R7: zero-length phases last one cycle each
        set_phases(0, 0, 0, 0);
        trig_i = 1'b1; step("R6"); trig_i = 1'b0;
        step("R7"); lit("R7", 3'b101);
        step("R7"); step("R7"); step("R7"); lit("R7", 3'b011);
        clr_i = 1'b1; step("R9"); clr_i = 1'b0;

        // Random section
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(49) == 0) begin
                tmo_cyc_i = CNT_W'($urandom_range(6));
                set_phases($urandom_range(5), $urandom_range(5), $urandom_range(5), $urandom_range(5));
                sig_en_i  = N_SIG'($urandom_range(15));
                sig_map_i = 8'($urandom_range(255));
            end
            class_en_i = ($urandom_range(7) != 0);
            if ($urandom_range(5) == 0) irq_pend_i = ~irq_pend_i;
            trig_i = ($urandom_range(19) == 0);
            clr_i  = ($urandom_range(11) == 0);
            step("");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule